// File: doc/BRIEF.md
# CRC Accumulate Instruction Unit

This block is the execution unit for a processor's CRC accumulate instructions. Each operation takes a running 32-bit checksum, a data operand of up to 64 bits and an instruction word. It returns the checksum updated with 1, 2, 4 or 8 data bytes. Two generator polynomials are available and one is chosen per operation: the common Ethernet one, 0x04C11DB7, and the Castagnoli one, 0x1EDC6F41. The arithmetic is bit-reflected (LSB first). No pre-inversion and no post-inversion is applied, so software can chain operations and add the customary inversions itself.

The unit decodes its own instruction fields from either of two encodings, selected by a state input. In the 32-bit state it extracts register indices, the polynomial bit and the size code, and reports the doubleword forms as undefined. In the 64-bit state it decodes a six-bit sub-opcode. Each result is registered and offered on a valid/ready output. The result, the undefined flag and the register indices are held until they are accepted, and a new operation can be taken every cycle.

Top module: `crc_insn_unit`

## Requirements
- R1: After reset, out_valid, out_undef and out_crc are all zero.
- R2: In the 32-bit state (in_wide_state=0), out_rm is insn[3:0], out_rd is insn[15:12] and out_rn is insn[19:16], each zero-extended to 5 bits. Index 15 is legal in any of these fields and does not make the operation undefined.
- R3: In the 32-bit state the select value {insn[9], insn[22:21]} picks the operation. Values 0, 1 and 2 give the standard polynomial over 1, 2 and 4 bytes. Values 4, 5 and 6 give the Castagnoli polynomial over 1, 2 and 4 bytes. Values 3 and 7 set out_undef=1 and out_crc=0.
- R4: In the 64-bit state (in_wide_state=1), the sub-opcode is insn[15:10]. Sub-opcodes 0x10 to 0x13 give the standard polynomial over 1, 2, 4 and 8 bytes. Sub-opcodes 0x14 to 0x17 give the Castagnoli polynomial over the same sizes. Any other sub-opcode sets out_undef=1 and out_crc=0. The register fields are out_rd=insn[4:0], out_rn=insn[9:5] and out_rm=insn[20:16].
- R5: The update is bit-reflected, using the reversed polynomials 0xEDB88320 (standard) and 0x82F63B78 (Castagnoli), with no initial or final inversion. Starting from 0xFFFFFFFF and inverting the final value, the nine ASCII bytes "123456789" give 0xCBF43926 (standard) and 0xE3069283 (Castagnoli).
- R6: Data bytes are folded lowest byte (bits 7:0) first. Only the low N bytes of in_data are used, and the bytes above them have no effect on the result.
- R7: Only in_acc[31:0] is used, and in_acc[63:32] has no effect on the result.
- R8: An operation is accepted when in_valid and in_ready are both high, and its result is on the outputs with out_valid=1 in the next cycle. While out_valid=1 and out_ready=0, in_ready is 0 and all outputs stay unchanged.
- R9: With out_ready held high, in_ready stays high, so one operation is accepted per cycle. out_valid falls in the cycle after a result is taken when no new operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_wide_state | input | 1 | 1 selects the 64-bit state encoding, 0 the 32-bit one |
| in_insn | input | 32 | Instruction word |
| in_acc | input | 64 | Running checksum operand (low 32 bits used) |
| in_data | input | 64 | Data operand, little-endian bytes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_crc | output | 32 | Updated checksum, zero when undefined |
| out_undef | output | 1 | Encoding is undefined |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | Checksum source register index |
| out_rm | output | 5 | Data source register index |

## Verification
The assertions assume that in_valid, the instruction word and both operands do not change between the falling and rising edges around acceptance. They also assume that the consumer may drop out_ready at any time. The bench drives every input only on falling clock edges, so the values seen at each rising edge are settled. It stalls the consumer only in a dedicated back-pressure sequence. The random stimulus draws from both states. Most instruction words are built from valid fields, and about a quarter are raw random words, so the undefined paths of both decoders are also reached.

// File: rtl/crcu_pkg.sv
package crcu_pkg;

    localparam int CRC_W = 32;
    localparam int REG_W = 5;

    // Bit-reversed generator polynomials for LSB-first arithmetic
    localparam logic [CRC_W-1:0] RPOLY_STD = 32'hEDB88320;
    localparam logic [CRC_W-1:0] RPOLY_CAS = 32'h82F63B78;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } sz_e;

    typedef struct packed {
        logic             undef;
        logic             cas;
        sz_e              size;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rm;
    } dec_t;

    // One byte through the reflected shift register
    function automatic logic [CRC_W-1:0] fold_byte(input logic [CRC_W-1:0] c,
                                                   input logic [7:0]       b,
                                                   input logic [CRC_W-1:0] rp);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-8){1'b0}}, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ rp) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/crcu_decode.sv
module crcu_decode
    import crcu_pkg::*;
(
    input  logic        wide_state,
    input  logic [31:0] insn,
    output dec_t        dec
);

    localparam logic [2:0] WIDE_GROUP = 3'b010;

    logic [5:0] sub_op;
    logic [2:0] narrow_sel;

    assign sub_op     = insn[15:10];
    assign narrow_sel = {insn[9], insn[22:21]};

    always_comb begin
        dec = '0;
        if (!wide_state) begin
            dec.rm    = {1'b0, insn[3:0]};
            dec.rd    = {1'b0, insn[15:12]};
            dec.rn    = {1'b0, insn[19:16]};
            dec.cas   = narrow_sel[2];
            dec.size  = sz_e'(narrow_sel[1:0]);
            // doubleword forms do not exist in the narrow state
            dec.undef = (narrow_sel[1:0] == SZ_DBL);
        end else begin
            dec.rd    = insn[4:0];
            dec.rn    = insn[9:5];
            dec.rm    = insn[20:16];
            dec.cas   = sub_op[2];
            dec.size  = sz_e'(sub_op[1:0]);
            dec.undef = (sub_op[5:3] != WIDE_GROUP);
        end
    end

endmodule

// File: rtl/crcu_fold.sv
module crcu_fold
    import crcu_pkg::*;
#(
    parameter int DATA_BYTES = 8
) (
    input  logic [CRC_W-1:0]        acc,
    input  logic [DATA_BYTES*8-1:0] data,
    input  logic                    cas,
    input  sz_e                     size,
    output logic [CRC_W-1:0]        crc
);

    localparam int HALF_BYTES = DATA_BYTES / 4;
    localparam int WORD_BYTES = DATA_BYTES / 2;

    logic [CRC_W-1:0] rpoly;
    logic [CRC_W-1:0] chain [0:DATA_BYTES];

    assign rpoly    = cas ? RPOLY_CAS : RPOLY_STD;
    assign chain[0] = acc;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_stage
        assign chain[g+1] = fold_byte(chain[g], data[g*8 +: 8], rpoly);
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: crc = chain[1];
            SZ_HALF: crc = chain[HALF_BYTES];
            SZ_WORD: crc = chain[WORD_BYTES];
            default: crc = chain[DATA_BYTES];
        endcase
    end

endmodule

// File: rtl/crc_insn_unit.sv
module crc_insn_unit
    import crcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_wide_state,
    input  logic [31:0]      in_insn,
    input  logic [63:0]      in_acc,
    input  logic [63:0]      in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CRC_W-1:0] out_crc,
    output logic             out_undef,
    output logic [REG_W-1:0] out_rd,
    output logic [REG_W-1:0] out_rn,
    output logic [REG_W-1:0] out_rm
);

    localparam int DATA_BYTES = 8;

    typedef struct packed {
        logic             valid;
        logic [CRC_W-1:0] crc;
        logic             undef;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rm;
    } hold_t;

    hold_t            s_d, s_q;
    dec_t             dec;
    logic [CRC_W-1:0] fold_crc;
    logic             unused_acc_hi;

    assign unused_acc_hi = ^in_acc[63:CRC_W];

    crcu_decode u_decode (
        .wide_state (in_wide_state),
        .insn       (in_insn),
        .dec        (dec)
    );

    crcu_fold #(.DATA_BYTES(DATA_BYTES)) u_fold (
        .acc  (in_acc[CRC_W-1:0]),
        .data (in_data),
        .cas  (dec.cas),
        .size (dec.size),
        .crc  (fold_crc)
    );

    assign in_ready = !s_q.valid || out_ready;

    always_comb begin
        s_d = s_q;
        if (s_q.valid && out_ready) begin
            s_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            s_d.valid = 1'b1;
            s_d.undef = dec.undef;
            s_d.crc   = dec.undef ? '0 : fold_crc;
            s_d.rd    = dec.rd;
            s_d.rn    = dec.rn;
            s_d.rm    = dec.rm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_crc   = s_q.crc;
    assign out_undef = s_q.undef;
    assign out_rd    = s_q.rd;
    assign out_rn    = s_q.rn;
    assign out_rm    = s_q.rm;

endmodule

// File: rtl/crc_insn_unit_chk.sv
module crc_insn_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_wide_state,
    input logic [31:0] in_insn,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_crc,
    input logic        out_undef,
    input logic [4:0]  out_rd,
    input logic [4:0]  out_rn,
    input logic [4:0]  out_rm
);

    // R8
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_crc) && $stable(out_undef)
                                       && $stable(out_rd) && $stable(out_rn) && $stable(out_rm)));

    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R2
    narrow_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_wide_state) |=> (!out_rd[4] && !out_rn[4] && !out_rm[4]));

    // R3
    narrow_dbl_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_wide_state && in_insn[22:21] == 2'b11) |=> out_undef);

    // R4
    wide_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_wide_state && in_insn[15:13] == 3'b010) |=> !out_undef);

    // R3
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_undef) |-> (out_crc == 32'h0));

endmodule

bind crc_insn_unit crc_insn_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_wide_state (in_wide_state),
    .in_insn       (in_insn),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_crc       (out_crc),
    .out_undef     (out_undef),
    .out_rd        (out_rd),
    .out_rn        (out_rn),
    .out_rm        (out_rm)
);

// File: tb/tb_crc_insn_unit.sv
module tb_crc_insn_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_wide_state = 1'b0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_acc = '0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_crc;
    logic        out_undef;
    logic [4:0]  out_rd, out_rn, out_rm;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    crc_insn_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_wide_state(in_wide_state), .in_insn(in_insn), .in_acc(in_acc),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_crc(out_crc), .out_undef(out_undef), .out_rd(out_rd),
        .out_rn(out_rn), .out_rm(out_rm)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] acc, input logic [63:0] data,
                                            input int nbytes, input bit cas);
        logic [31:0] rp, c;
        rp = rev32(cas ? 32'h1EDC6F41 : 32'h04C11DB7);
        c = acc;
        for (int i = 0; i < nbytes * 8; i++) begin
            c = (c[0] ^ data[i]) ? ((c >> 1) ^ rp) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [31:0] a32_word(input bit cas, input logic [1:0] sz,
                                             input logic [3:0] rd, rn, rm);
        logic [31:0] w;
        w = 32'h0;
        w[22:21] = sz; w[9] = cas; w[19:16] = rn; w[15:12] = rd; w[3:0] = rm;
        return w;
    endfunction

    function automatic logic [31:0] a64_word(input logic [5:0] sub, input logic [4:0] rd, rn, rm);
        logic [31:0] w;
        w = 32'h0;
        w[15:10] = sub; w[4:0] = rd; w[9:5] = rn; w[20:16] = rm;
        return w;
    endfunction

    task automatic expect_of(input bit wide, input logic [31:0] w, input logic [63:0] acc,
                             input logic [63:0] data, output logic [31:0] crc, output bit undef,
                             output logic [4:0] rd, rn, rm);
        int nb;
        bit cas;
        if (!wide) begin
            rd = {1'b0, w[15:12]}; rn = {1'b0, w[19:16]}; rm = {1'b0, w[3:0]};
            undef = (w[22:21] == 2'b11);
            cas = w[9];
            nb = 1 << w[22:21];
        end else begin
            rd = w[4:0]; rn = w[9:5]; rm = w[20:16];
            undef = (w[15:13] != 3'b010);
            cas = w[12];
            nb = 1 << w[11:10];
        end
        crc = undef ? 32'h0 : ref_crc(acc[31:0], data, nb, cas);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wide, input logic [31:0] w, input logic [63:0] acc,
                         input logic [63:0] data);
        @(negedge clk);
        in_valid = 1'b1; in_wide_state = wide; in_insn = w; in_acc = acc; in_data = data;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string req, input bit wide, input logic [31:0] w,
                             input logic [63:0] acc, input logic [63:0] data);
        logic [31:0] ec;
        bit eu;
        logic [4:0] erd, ern, erm;
        expect_of(wide, w, acc, data, ec, eu, erd, ern, erm);
        issue(wide, w, acc, data);
        chk(req, {31'b0, out_valid}, 32'd1);
        chk(req, out_crc, ec);
        chk(req, {31'b0, out_undef}, {31'b0, eu});
        chk(req, {out_rd, out_rn, out_rm}, {17'b0, erd, ern, erm});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", {30'b0, out_valid, out_undef}, 32'd0);
        chk("R1", out_crc, 32'd0);
        rst_n = 1'b1;

        // R5 known vectors via chained R3 operations
        for (int p = 0; p < 2; p++) begin
            issue(1'b0, a32_word(p[0], 2'd2, 4'd1, 4'd2, 4'd3), 64'hFFFFFFFF, 64'h34333231);
            a = out_crc;
            issue(1'b0, a32_word(p[0], 2'd2, 4'd1, 4'd2, 4'd3), {32'h0, a}, 64'h38373635);
            a = out_crc;
            issue(1'b0, a32_word(p[0], 2'd0, 4'd1, 4'd2, 4'd3), {32'h0, a}, 64'h39);
            chk("R5", ~out_crc, p ? 32'hE3069283 : 32'hCBF43926);
        end

        // R3 undefined narrow forms, R2 index 15
        run_check("R3", 1'b0, a32_word(1'b0, 2'd3, 4'd1, 4'd2, 4'd3), 64'h1234, 64'h5678);
        run_check("R3", 1'b0, a32_word(1'b1, 2'd3, 4'd4, 4'd5, 4'd6), 64'h1234, 64'h5678);
        run_check("R2", 1'b0, a32_word(1'b1, 2'd1, 4'd15, 4'd15, 4'd15), 64'hDEAD, 64'hBEEF);
        chk("R2", {31'b0, out_undef}, 32'd0);
        // R4 wide forms and neighbouring sub-opcodes
        for (int s = 6'h0F; s <= 6'h18; s++)
            run_check("R4", 1'b1, a64_word(s[5:0], 5'd31, 5'd17, 5'd9), 64'hFFFF_FFFF_A5A5_0001,
                      64'h0123_4567_89AB_CDEF);

        // R6 upper data bytes ignored, R7 upper accumulator ignored
        issue(1'b0, a32_word(1'b0, 2'd0, 4'd0, 4'd0, 4'd0), 64'h0000_0000_1111_2222, 64'h0000_0000_0000_00A7);
        a = out_crc;
        issue(1'b0, a32_word(1'b0, 2'd0, 4'd0, 4'd0, 4'd0), 64'hFFFF_EEEE_1111_2222, 64'hFFFF_FFFF_FFFF_FFA7);
        chk("R6", out_crc, a);
        chk("R7", out_crc, ref_crc(32'h1111_2222, 64'hA7, 1, 1'b0));
        issue(1'b1, a64_word(6'h16, 5'd0, 5'd0, 5'd0), 64'h0, 64'h0102_0304_0506_0708);
        chk("R6", out_crc, ref_crc(32'h0, 64'h0506_0708, 4, 1'b1));

        // R8 back-pressure
        @(negedge clk);
        out_ready = 1'b0;
        issue(1'b0, a32_word(1'b0, 2'd2, 4'd1, 4'd1, 4'd1), 64'h11, 64'h22);
        a = out_crc;
        in_valid = 1'b1; in_wide_state = 1'b0;
        in_insn = a32_word(1'b1, 2'd1, 4'd2, 4'd2, 4'd2); in_acc = 64'h33; in_data = 64'h44;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8", {30'b0, in_ready, out_valid}, 32'd1);
            chk("R8", out_crc, a);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", out_crc, ref_crc(32'h33, 64'h44, 2, 1'b1));
        @(posedge clk);
        @(negedge clk);
        // R9 drains once taken with no new operation
        chk("R9", {31'b0, out_valid}, 32'd0);

        // R9 back-to-back one per cycle
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1; in_wide_state = 1'b1;
            in_insn = a64_word(6'h13, 5'd1, 5'd2, 5'd3); in_acc = k; in_data = 64'hFEED + k;
            @(posedge clk);
            @(negedge clk);
            chk("R9", {31'b0, in_ready & out_valid}, 32'd1);
            chk("R9", out_crc, ref_crc(k, 64'hFEED + k, 8, 1'b0));
        end
        in_valid = 1'b0;

        // random mix, R3 R4 R6
        for (int n = 0; n < 400; n++) begin
            bit wide;
            logic [31:0] w;
            wide = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) w = $urandom;
            else if (wide) w = a64_word({3'b010, 3'($urandom_range(0, 7))}, 5'($urandom), 5'($urandom), 5'($urandom));
            else w = a32_word(1'($urandom), 2'($urandom_range(0, 2)), 4'($urandom), 4'($urandom), 4'($urandom));
            b = $urandom;
            run_check(wide ? "R4" : "R3", wide, w, {32'($urandom), b}, {32'($urandom), 32'($urandom)});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule